// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is a boundary-scan test access port. A serial test clock, a mode-select line and a serial data input walk the standard sixteen-state TAP machine. A 4-bit instruction register selects which data register sits between the serial input and the serial output. The data registers are a 1-bit bypass stage, a 32-bit identification word and a boundary chain of parameter length. The boundary chain has a shift stage and an update stage.

The current instruction is also decoded into control outputs for the surrounding chip:
- `drive_from_bnd`: drive the device pins from the boundary update stage.
- `force_hiz`: place every output driver in high impedance.
- `clamp_req`: hold the outputs at the boundary values while the bypass bit is scanned.
- `core_rst_pulse`: a one-cycle reset pulse to the core logic that is not part of boundary scan.

`scan_out` changes on the falling edge of the test clock. `scan_out_en` marks the cycles in which a tester should sample it.

Top module: `tap_ctrl`

## Requirements
- R1: A synchronous `tap_rst`, or five test-clock cycles with `mode_sel` high from any state, brings the TAP to Test-Logic-Reset. That state loads the identification instruction (1011) into the instruction register. After reset `scan_out_en`, `bnd_out` and all control outputs are 0.
- R2: In Capture-IR the instruction shift stage loads 0001. It shifts least significant bit first, with `scan_in` entering at bit 3. The shifted value becomes the current instruction on the rising edge that ends Update-IR.
- R3: Opcodes 0000 (external test) and 1000 (sample/preload) place the boundary chain on the scan path. Opcode 1011 places the identification register on the scan path. Every other opcode places the bypass bit on the scan path; this covers 1111, 0111, 0100, 1100 and all reserved codes.
- R4: The identification word captured in Capture-DR is {revision[31:28]=0, device code[27:12]=0xC002 by default, manufacturer code[11:1]=0x034, bit0=1}, which is 0x0C002069. It is shifted out from bit 0.
- R5: The bypass bit captures 0 and delays the serial data by exactly one shift.
- R6: Under a boundary opcode, Capture-DR loads `pin_in` into the shift stage, with bit 0 shifted out first. Update-DR copies the shift stage to `bnd_out`. Under any other opcode, `bnd_out` holds its value through a full DR scan.
- R7: `force_hiz` is 1 only while opcode 0111 is current.
- R8: `drive_from_bnd` is 1 while opcode 0000 or 0100 is current. `clamp_req` is 1 only while opcode 0100 is current.
- R9: While opcode 1100 is current, `core_rst_pulse` is 1 for exactly the first cycle of each entry into Run-Test/Idle and 0 otherwise.
- R10: `scan_out` and `scan_out_en` change only on the falling edge of `scan_clk`. `scan_out_en` is 1 exactly in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high test reset |
| mode_sel | input | 1 | Mode select steering the TAP state machine |
| scan_in | input | 1 | Serial test data input |
| scan_out | output | 1 | Serial test data output, falling-edge timed |
| scan_out_en | output | 1 | Enable for scan_out, high in shift states |
| pin_in | input | BSR_LEN | Pin values captured into the boundary chain |
| bnd_out | output | BSR_LEN | Boundary update stage driving the pins |
| drive_from_bnd | output | 1 | Pins driven from bnd_out |
| force_hiz | output | 1 | All output drivers to high impedance |
| clamp_req | output | 1 | Clamp request |
| core_rst_pulse | output | 1 | One-cycle reset for non-scan core logic |

## Verification
Every opcode, including two reserved codes, is loaded and then identified by what its data scan returns:
- The bypass bit shows up as a one-bit delay after a leading 0.
- The identification word comes out bit 0 first; a reversed or misplaced field breaks the comparison.
- The boundary chain returns the pins ahead of the shifted-in data.

After each scan, `bnd_out` is compared against the last shifted bits, or against its old value. This catches an update that fires under clamp or bypass. The reset-pulse opcode is checked on two entries into Run-Test/Idle and in the idle cycle that follows, so a level instead of a pulse fails. `scan_out` is sampled just after a rising edge and again after the falling edge, so an output stage timed on the wrong edge shows the next bit too early.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST   = 4'b0000;
    localparam opcode_t OP_SAMPLE   = 4'b1000;
    localparam opcode_t OP_IDCODE   = 4'b1011;
    localparam opcode_t OP_BYPASS   = 4'b1111;
    localparam opcode_t OP_HIGHZ    = 4'b0111;
    localparam opcode_t OP_CLAMP    = 4'b0100;
    localparam opcode_t OP_CORE_RST = 4'b1100;
    localparam opcode_t IR_CAP_PAT  = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BND} dr_sel_e;

    typedef struct packed {
        dr_sel_e dr_sel;
        logic    drive_bnd;
        logic    hiz;
        logic    clamp;
        logic    core_rst;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            ST_TLR:      return m ? ST_TLR    : ST_RTI;
            ST_RTI:      return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR:   return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR:   return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:    return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR:   return m ? ST_UPD_DR : ST_PAUSE_DR;
            ST_PAUSE_DR: return m ? ST_EX2_DR : ST_PAUSE_DR;
            ST_EX2_DR:   return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR:   return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR:   return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR:   return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:    return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR:   return m ? ST_UPD_IR : ST_PAUSE_IR;
            ST_PAUSE_IR: return m ? ST_EX2_IR : ST_PAUSE_IR;
            ST_EX2_IR:   return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR:   return m ? ST_SEL_DR : ST_RTI;
            default:     return ST_TLR;
        endcase
    endfunction

    function automatic tap_ctl_t tap_decode(opcode_t op);
        tap_ctl_t c;
        c.dr_sel    = DR_BYP;
        c.drive_bnd = 1'b0;
        c.hiz       = 1'b0;
        c.clamp     = 1'b0;
        c.core_rst  = 1'b0;
        case (op)
            OP_EXTEST: begin
                c.dr_sel    = DR_BND;
                c.drive_bnd = 1'b1;
            end
            OP_SAMPLE:   c.dr_sel = DR_BND;
            OP_IDCODE:   c.dr_sel = DR_ID;
            OP_HIGHZ:    c.hiz    = 1'b1;
            OP_CLAMP: begin
                c.clamp     = 1'b1;
                c.drive_bnd = 1'b1;
            end
            OP_CORE_RST: c.core_rst = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic [31:0] id_word(logic [3:0] rev, logic [15:0] dev, logic [10:0] mfr);
        return {rev, dev, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    output tap_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, mode);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       sdi,
    output logic       ir_sdo,
    output opcode_t    cur_op
);
    opcode_t sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= IR_CAP_PAT;
        end else if (state == ST_CAP_IR) begin
            sh_q <= IR_CAP_PAT;
        end else if (state == ST_SH_IR) begin
            sh_q <= {sdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_TLR) cur_op <= OP_IDCODE;
        else if (state == ST_UPD_IR) cur_op <= sh_q;
    end

    assign ir_sdo = sh_q[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter logic [31:0] ID_VAL  = 32'h0000_0001
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               sdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_sdo,
    output logic [BSR_LEN-1:0] bnd_upd
);
    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsh_q;

    logic cap, sh;
    assign cap = (state == ST_CAP_DR);
    assign sh  = (state == ST_SH_DR);

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q   <= 1'b0;
            id_q    <= '0;
            bsh_q   <= '0;
            bnd_upd <= '0;
        end else begin
            if (cap && sel == DR_BYP)     byp_q <= 1'b0;
            else if (sh && sel == DR_BYP) byp_q <= sdi;

            if (cap && sel == DR_ID)      id_q <= ID_VAL;
            else if (sh && sel == DR_ID)  id_q <= {sdi, id_q[ID_W-1:1]};

            if (cap && sel == DR_BND)     bsh_q <= pin_in;
            else if (sh && sel == DR_BND) begin
                if (BSR_LEN == 1) bsh_q <= sdi;
                else              bsh_q <= {sdi, bsh_q[BSR_LEN-1:1]};
            end

            if (state == ST_UPD_DR && sel == DR_BND) bnd_upd <= bsh_q;
        end
    end

    always_comb begin
        case (sel)
            DR_ID:   dr_sdo = id_q[0];
            DR_BND:  dr_sdo = bsh_q[0];
            default: dr_sdo = byp_q;
        endcase
    end
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int          BSR_LEN     = 8,
    parameter logic [15:0] DEVICE_CODE = 16'hC002,
    parameter logic [3:0]  REVISION    = 4'h0,
    parameter logic [10:0] MFR_CODE    = 11'h034
) (
    input  logic               scan_clk,
    input  logic               tap_rst,
    input  logic               mode_sel,
    input  logic               scan_in,
    output logic               scan_out,
    output logic               scan_out_en,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic [BSR_LEN-1:0] bnd_out,
    output logic               drive_from_bnd,
    output logic               force_hiz,
    output logic               clamp_req,
    output logic               core_rst_pulse
);
    localparam logic [31:0] ID_VAL = id_word(REVISION, DEVICE_CODE, MFR_CODE);

    tap_state_e state_q;
    opcode_t    cur_op;
    tap_ctl_t   ctl;
    logic       ir_sdo, dr_sdo, sdo_mux;
    logic       was_idle_q;

    tap_fsm u_fsm (
        .clk   (scan_clk),
        .rst   (tap_rst),
        .mode  (mode_sel),
        .state (state_q)
    );

    tap_ir u_ir (
        .clk    (scan_clk),
        .rst    (tap_rst),
        .state  (state_q),
        .sdi    (scan_in),
        .ir_sdo (ir_sdo),
        .cur_op (cur_op)
    );

    assign ctl = tap_decode(cur_op);

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
        .clk     (scan_clk),
        .rst     (tap_rst),
        .state   (state_q),
        .sel     (ctl.dr_sel),
        .sdi     (scan_in),
        .pin_in  (pin_in),
        .dr_sdo  (dr_sdo),
        .bnd_upd (bnd_out)
    );

    assign sdo_mux = (state_q == ST_SH_IR) ? ir_sdo : dr_sdo;

    // Output stage retimed to the falling edge of the test clock.
    always_ff @(negedge scan_clk) begin
        if (tap_rst) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out    <= sdo_mux;
            scan_out_en <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
        end
    end

    // Remembers idle occupancy so the core reset fires once per entry.
    always_ff @(posedge scan_clk) begin
        if (tap_rst) was_idle_q <= 1'b0;
        else         was_idle_q <= (state_q == ST_RTI);
    end

    assign core_rst_pulse = ctl.core_rst && (state_q == ST_RTI) && !was_idle_q;
    assign drive_from_bnd = ctl.drive_bnd;
    assign force_hiz      = ctl.hiz;
    assign clamp_req      = ctl.clamp;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               scan_clk,
    input logic               tap_rst,
    input tap_state_e         state_q,
    input logic [BSR_LEN-1:0] bnd_out,
    input logic               scan_out_en,
    input logic               drive_from_bnd,
    input logic               force_hiz,
    input logic               clamp_req,
    input logic               core_rst_pulse
);
    // R6: the update stage moves only on the edge that leaves Update-DR
    p_bnd_hold_r6: assert property (@(posedge scan_clk) disable iff (tap_rst)
        (state_q != ST_UPD_DR) |=> $stable(bnd_out));

    // R7: high impedance never combines with driving from the boundary
    p_hiz_excl_r7: assert property (@(posedge scan_clk) disable iff (tap_rst)
        force_hiz |-> !drive_from_bnd);

    // R8: a clamp always drives the pins from the boundary stage
    p_clamp_drive_r8: assert property (@(posedge scan_clk) disable iff (tap_rst)
        clamp_req |-> drive_from_bnd);

    // R9: the core reset lasts one cycle and only in Run-Test/Idle
    p_pulse_single_r9: assert property (@(posedge scan_clk) disable iff (tap_rst)
        core_rst_pulse |=> !core_rst_pulse);

    p_pulse_idle_r9: assert property (@(posedge scan_clk) disable iff (tap_rst)
        core_rst_pulse |-> (state_q == ST_RTI));

    // R10: output enable tracks the shift states
    p_oe_shift_r10: assert property (@(posedge scan_clk) disable iff (tap_rst)
        scan_out_en == ((state_q == ST_SH_IR) || (state_q == ST_SH_DR)));
endmodule

bind tap_ctrl tap_ctrl_chk #(.BSR_LEN(BSR_LEN)) chk_i (
    .scan_clk       (scan_clk),
    .tap_rst        (tap_rst),
    .state_q        (state_q),
    .bnd_out        (bnd_out),
    .scan_out_en    (scan_out_en),
    .drive_from_bnd (drive_from_bnd),
    .force_hiz      (force_hiz),
    .clamp_req      (clamp_req),
    .core_rst_pulse (core_rst_pulse)
);

// File: tb/tap_ctrl_tb_top.sv
module tap_ctrl_tb_top;
    localparam int          N      = 8;
    localparam int          SLEN   = 40;
    localparam logic [31:0] ID_EXP = 32'h0C00_2069;

    // vector: op[9:6] kind[5:4] (0 byp,1 id,2 bnd) hiz[3] clamp[2] drive[1] crst[0]
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        {4'b0000, 2'd2, 4'b0010},
        {4'b1111, 2'd0, 4'b0000},
        {4'b1011, 2'd1, 4'b0000},
        {4'b0111, 2'd0, 4'b1000},
        {4'b0100, 2'd0, 4'b0110},
        {4'b1000, 2'd2, 4'b0000},
        {4'b1100, 2'd0, 4'b0001},
        {4'b0101, 2'd0, 4'b0000},
        {4'b0011, 2'd0, 4'b0000}
    };

    logic         scan_clk = 1'b0;
    logic         tap_rst = 1'b1;
    logic         mode_sel = 1'b1;
    logic         scan_in = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         scan_out, scan_out_en;
    logic [N-1:0] bnd_out;
    logic         drive_from_bnd, force_hiz, clamp_req, core_rst_pulse;

    int  checks = 0;
    int  fails = 0;
    bit  done = 0;

    always #4 scan_clk = ~scan_clk;

    tap_ctrl #(.BSR_LEN(N)) dut_i (
        .scan_clk(scan_clk), .tap_rst(tap_rst), .mode_sel(mode_sel), .scan_in(scan_in),
        .scan_out(scan_out), .scan_out_en(scan_out_en), .pin_in(pin_in), .bnd_out(bnd_out),
        .drive_from_bnd(drive_from_bnd), .force_hiz(force_hiz), .clamp_req(clamp_req),
        .core_rst_pulse(core_rst_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic so, output logic oe);
        mode_sel = m;
        scan_in  = d;
        so = scan_out;
        oe = scan_out_en;
        @(posedge scan_clk);
        @(negedge scan_clk);
        #1;
    endtask

    task automatic go(input logic m);
        logic a, b;
        step(m, 1'b0, a, b);
    endtask

    // From Run-Test/Idle: load an opcode, return captured IR bits, end in Run-Test/Idle.
    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap, output logic oe_ok);
        logic oe;
        oe_ok = 1'b1;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i], cap[i], oe);
            oe_ok &= oe;
        end
        go(1); go(0);
    endtask

    task automatic scan_dr(input logic [63:0] din, output logic [63:0] dout, output logic oe_ok);
        logic oe;
        dout  = '0;
        oe_ok = 1'b1;
        go(1); go(0); go(0);
        for (int i = 0; i < SLEN; i++) begin
            step(i == SLEN - 1, din[i], dout[i], oe);
            oe_ok &= oe;
        end
        go(1); go(0);
    endtask

    function automatic logic [63:0] expect_dr(input logic [1:0] kind, input logic [63:0] din,
                                               input logic [N-1:0] pins);
        logic [63:0] e;
        case (kind)
            2'd1:    e = {din[31:0], ID_EXP};
            2'd2:    e = {din[55:0], pins};
            default: e = {din[62:0], 1'b0};
        endcase
        return e & ((64'd1 << SLEN) - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge scan_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] din, dout, exp;
        logic [3:0]  cap;
        logic        oe_ok;
        logic [N-1:0] bnd_exp;

        repeat (3) @(posedge scan_clk);
        @(negedge scan_clk);
        #1 tap_rst = 1'b0;

        // R1 reset state
        chk(scan_out_en == 1'b0, "R1 oe after reset", scan_out_en, 0);
        chk({drive_from_bnd, force_hiz, clamp_req, core_rst_pulse} == 4'b0, "R1 controls after reset",
            {drive_from_bnd, force_hiz, clamp_req, core_rst_pulse}, 0);
        chk(bnd_out == '0, "R1 bnd_out after reset", bnd_out, 0);
        go(0);
        chk(scan_out_en == 1'b0, "R10 oe off in idle", scan_out_en, 0);

        // R1/R4/R10: identification selected after reset, falling-edge timing
        go(1); go(0); go(0);
        chk(scan_out == ID_EXP[0], "R10 first id bit", scan_out, ID_EXP[0]);
        mode_sel = 1'b0;
        @(posedge scan_clk);
        #1;
        chk(scan_out == ID_EXP[0], "R10 no change on rising edge", scan_out, ID_EXP[0]);
        @(negedge scan_clk);
        #1;
        chk(scan_out == ID_EXP[1], "R10 change on falling edge", scan_out, ID_EXP[1]);
        for (int i = 0; i < 6; i++) go(1);
        go(0);
        din = 64'h0000_00A5_5A3C_C3F0;
        scan_dr(din, dout, oe_ok);
        chk(dout == expect_dr(2'd1, din, pin_in), "R1 R4 id after reset", dout, expect_dr(2'd1, din, pin_in));
        chk(oe_ok, "R10 oe during shift", oe_ok, 1);

        // Vector table walk: R2 R3 R5 R6 R7 R8 R9
        bnd_exp = '0;
        for (int v = 0; v < NV; v++) begin
            logic [3:0] op;
            logic [1:0] kind;
            op   = VEC[v][9:6];
            kind = VEC[v][5:4];
            pin_in = N'(8'h3C ^ (v * 8'h11));
            load_ir(op, cap, oe_ok);
            chk(cap == 4'b0001, "R2 capture pattern", cap, 4'b0001);
            chk(oe_ok, "R10 oe during IR shift", oe_ok, 1);
            chk(core_rst_pulse == VEC[v][0], "R9 pulse on idle entry", core_rst_pulse, VEC[v][0]);
            chk(force_hiz == VEC[v][3], "R7 high impedance", force_hiz, VEC[v][3]);
            chk(clamp_req == VEC[v][2], "R8 clamp", clamp_req, VEC[v][2]);
            chk(drive_from_bnd == VEC[v][1], "R8 drive from boundary", drive_from_bnd, VEC[v][1]);
            go(0);
            chk(core_rst_pulse == 1'b0, "R9 single cycle", core_rst_pulse, 0);
            din = {32'hC3A5_0F96 ^ (v * 32'h0101_0101), 32'h5A5A_1234 + v};
            scan_dr(din, dout, oe_ok);
            exp = expect_dr(kind, din, pin_in);
            chk(dout == exp, (kind == 2'd0) ? "R3 R5 bypass path" : "R3 R4 R6 selected path", dout, exp);
            if (kind == 2'd2) bnd_exp = din[SLEN-1 -: N];
            chk(bnd_out == bnd_exp, "R6 boundary update stage", bnd_out, bnd_exp);
            chk(core_rst_pulse == VEC[v][0], "R9 pulse on second entry", core_rst_pulse, VEC[v][0]);
        end

        // R1: five cycles with mode_sel high from a bypass instruction return to identification
        load_ir(4'b1111, cap, oe_ok);
        for (int i = 0; i < 5; i++) go(1);
        go(0);
        din = 64'h0000_0012_3456_789A;
        scan_dr(din, dout, oe_ok);
        chk(dout == expect_dr(2'd1, din, pin_in), "R1 five-high reset", dout, expect_dr(2'd1, din, pin_in));

        // R1: synchronous reset mid-scan
        load_ir(4'b0111, cap, oe_ok);
        go(1); go(0); go(0);
        tap_rst = 1'b1;
        @(posedge scan_clk);
        @(negedge scan_clk);
        #1 tap_rst = 1'b0;
        chk(force_hiz == 1'b0 && scan_out_en == 1'b0 && bnd_out == '0, "R1 reset clears",
            {force_hiz, scan_out_en, bnd_out}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule